// File: doc/BRIEF.md
# Mode-Aware Load Extender and Right Shifter

This unit sits in a 64-bit integer execution datapath and has two jobs, selected on each cycle by an operation select. In load mode it takes the raw data returned for an aligned memory access and turns it into a 64-bit register value. The access can be 8, 16, 32 or 64 bits wide. Byte and halfword values are extended as signed or unsigned, as the instruction asks. A 32-bit value is extended according to the machine's current execution mode: sign extension in 64-bit mode, and zero extension in 32-bit mode so that older 32-bit programs see the values they expect.

In shift mode it performs a right shift, either logical or arithmetic, on a 32-bit or a 64-bit operand. The operand width sets the bit that fills vacated positions (bit 31 or bit 63) and sets how many shift-amount bits are used. A 32-bit result is widened into the upper half of the register from its bit 31.

The result is registered. A valid input produces a valid 64-bit result one cycle later. The output data holds its value on idle cycles.

Top module: `xt_shift_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released with no input issued, `res_valid` is 0 and `res_data` is 0.
- R2: `res_valid` equals the value `in_valid` had one clock earlier.
- R3: For load operations (`op_shift`=0) with `ld_size`=0 (byte) or 1 (halfword), the low 8 or 16 bits of `ld_data` are sign-extended when `ld_signed`=1 and zero-extended when `ld_signed`=0.
- R4: For a load with `ld_size`=2 (32-bit word) and `mode64`=1, bits 31:0 of `ld_data` are sign-extended to 64 bits, and `ld_signed` has no effect.
- R5: For a load with `ld_size`=2 and `mode64`=0, bits 31:0 of `ld_data` are zero-extended to 64 bits, and `ld_signed` has no effect.
- R6: For a load with `ld_size`=3 (doubleword), `res_data` equals `ld_data` in either mode.
- R7: For byte, halfword and word loads, the bits of `ld_data` above the access size do not affect the result.
- R8: For shifts (`op_shift`=1) with `sh_w64`=1, the operand is shifted right by `sh_amt[5:0]`. Vacated bits are filled from bit 63 when `sh_arith`=1 and with zeros when `sh_arith`=0.
- R9: For shifts with `sh_w64`=0, only `sh_src[31:0]` is shifted, by `sh_amt[4:0]`. Vacated bits are filled from bit 31 when `sh_arith`=1 and with zeros otherwise. `sh_amt[5]` and `sh_src[63:32]` have no effect.
- R10: The 32-bit shift result is sign-extended from its bit 31 into bits 63:32 when `sh_arith`=1, and zero-extended when `sh_arith`=0.
- R11: On a cycle with `in_valid`=0, `res_data` keeps its previous value on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| op_shift | input | 1 | 0 = load shaping, 1 = right shift |
| ld_data | input | 64 | Raw load data, right-justified |
| ld_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| ld_signed | input | 1 | Signed extension for byte and halfword loads |
| mode64 | input | 1 | 1 = 64-bit execution mode, 0 = 32-bit mode |
| sh_src | input | 64 | Shift operand |
| sh_amt | input | 6 | Shift amount |
| sh_arith | input | 1 | 1 = arithmetic, 0 = logical shift |
| sh_w64 | input | 1 | 1 = 64-bit operand, 0 = 32-bit operand |
| res_valid | output | 1 | Result valid |
| res_data | output | 64 | Registered result |

## Verification
Every path in this unit runs through a single register stage, so a wrong extension choice or a wrong fill shows up in `res_data` in the cycle right after the operation is issued. The bench therefore puts a set bit next to each extension boundary and next to the shift fill positions, and reads the result one cycle later. A bad valid flag, or a data register that does not hold, shows on the next idle cycle. The bench checks this by inserting an idle cycle with changed inputs after a valid result.

// File: rtl/xt_shift_unit.sv
module xt_shift_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        op_shift,
  input  logic [63:0] ld_data,
  input  logic [1:0]  ld_size,
  input  logic        ld_signed,
  input  logic        mode64,
  input  logic [63:0] sh_src,
  input  logic [5:0]  sh_amt,
  input  logic        sh_arith,
  input  logic        sh_w64,
  output logic        res_valid,
  output logic [63:0] res_data
);

  logic [63:0] ld_val;
  logic [63:0] sh64_val;
  logic [31:0] sh32_low;
  logic [63:0] sh32_val;
  logic [63:0] next_val;

  always_comb begin
    unique case (ld_size)
      2'd0: ld_val = {{56{ld_signed & ld_data[7]}},  ld_data[7:0]};
      2'd1: ld_val = {{48{ld_signed & ld_data[15]}}, ld_data[15:0]};
      2'd2: ld_val = {{32{mode64 & ld_data[31]}},    ld_data[31:0]};
      default: ld_val = ld_data;
    endcase
  end

  assign sh64_val = sh_arith ? 64'($signed(sh_src) >>> sh_amt)
                             : sh_src >> sh_amt;
  assign sh32_low = sh_arith ? 32'($signed(sh_src[31:0]) >>> sh_amt[4:0])
                             : sh_src[31:0] >> sh_amt[4:0];
  assign sh32_val = {{32{sh_arith & sh32_low[31]}}, sh32_low};

  assign next_val = !op_shift ? ld_val : (sh_w64 ? sh64_val : sh32_val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) res_data <= next_val;
    end
  end

endmodule

module xt_shift_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        op_shift,
  input logic [63:0] ld_data,
  input logic [1:0]  ld_size,
  input logic        ld_signed,
  input logic        mode64,
  input logic [63:0] sh_src,
  input logic [5:0]  sh_amt,
  input logic        sh_arith,
  input logic        sh_w64,
  input logic        res_valid,
  input logic [63:0] res_data
);

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (!res_valid && res_data == 64'd0));

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);

  p_idle_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !res_valid);

  p_unsigned_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_shift && ld_size == 2'd0 && !ld_signed)
      |=> res_data[63:8] == 56'd0);

  p_word64_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_shift && ld_size == 2'd2 && mode64)
      |=> res_data == {{32{$past(ld_data[31])}}, $past(ld_data[31:0])});

  p_word32_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_shift && ld_size == 2'd2 && !mode64)
      |=> res_data == {32'd0, $past(ld_data[31:0])});

  p_dword_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_shift && ld_size == 2'd3)
      |=> res_data == $past(ld_data));

  p_logical_top_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_shift && sh_w64 && !sh_arith && sh_amt != 6'd0)
      |=> !res_data[63]);

  p_sh32_upper_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_shift && !sh_w64)
      |=> res_data[63:32] == ($past(sh_arith) ? {32{res_data[31]}} : 32'd0));

  p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && $past(rst_n)) |=> $stable(res_data));

endmodule

bind xt_shift_unit xt_shift_unit_chk u_chk (.*);

// File: tb/xt_shift_unit_test.sv
module xt_shift_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        op_shift;
  logic [63:0] ld_data;
  logic [1:0]  ld_size;
  logic        ld_signed;
  logic        mode64;
  logic [63:0] sh_src;
  logic [5:0]  sh_amt;
  logic        sh_arith;
  logic        sh_w64;
  logic        res_valid;
  logic [63:0] res_data;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  xt_shift_unit uut (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_load(input logic [63:0] d, input logic [1:0] sz, input logic sgn,
                         input logic m64, input logic [63:0] exp, input string tag);
    @(negedge clk);
    in_valid = 1'b1; op_shift = 1'b0; ld_data = d; ld_size = sz;
    ld_signed = sgn; mode64 = m64;
    sh_src = 64'hFFFF_FFFF_FFFF_FFFF; sh_amt = 6'd1;
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, res_data, exp);
    check("R2", {63'd0, res_valid}, 64'd1);
  endtask

  task automatic do_shift(input logic [63:0] s, input logic [5:0] a, input logic ar,
                          input logic w64, input logic [63:0] exp, input string tag);
    @(negedge clk);
    in_valid = 1'b1; op_shift = 1'b1; sh_src = s; sh_amt = a;
    sh_arith = ar; sh_w64 = w64; ld_data = 64'h5555_5555_5555_5555;
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, res_data, exp);
  endtask

  task automatic test_reset();
    rst_n = 1'b0; in_valid = 1'b0; op_shift = 1'b0; ld_data = '0; ld_size = '0;
    ld_signed = 1'b0; mode64 = 1'b1; sh_src = '0; sh_amt = '0; sh_arith = 1'b0; sh_w64 = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 valid", {63'd0, res_valid}, 64'd0);
    check("R1 data", res_data, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {63'd0, res_valid}, 64'd0);
  endtask

  task automatic test_byte_half();
    do_load(64'hDEAD_BEEF_CAFE_1280, 2'd0, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FF80, "R3 byte signed");
    do_load(64'hDEAD_BEEF_CAFE_1280, 2'd0, 1'b0, 1'b0, 64'h0000_0000_0000_0080, "R3 R7 byte unsigned");
    do_load(64'h1234_5678_9ABC_8001, 2'd1, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_8001, "R3 half signed");
    do_load(64'h1234_5678_9ABC_8001, 2'd1, 1'b0, 1'b1, 64'h0000_0000_0000_8001, "R3 R7 half unsigned");
    do_load(64'hFFFF_FFFF_FFFF_FF7F, 2'd0, 1'b1, 1'b1, 64'h0000_0000_0000_007F, "R7 byte positive");
  endtask

  task automatic test_word();
    do_load(64'h1234_5678_8765_4321, 2'd2, 1'b0, 1'b1, 64'hFFFF_FFFF_8765_4321, "R4 word mode64");
    do_load(64'h1234_5678_8765_4321, 2'd2, 1'b1, 1'b1, 64'hFFFF_FFFF_8765_4321, "R4 signed ignored");
    do_load(64'hFFFF_FFFF_7FFF_0000, 2'd2, 1'b1, 1'b1, 64'h0000_0000_7FFF_0000, "R4 R7 positive word");
    do_load(64'h1234_5678_8765_4321, 2'd2, 1'b1, 1'b0, 64'h0000_0000_8765_4321, "R5 word mode32");
    do_load(64'hFFFF_FFFF_8000_0000, 2'd2, 1'b0, 1'b0, 64'h0000_0000_8000_0000, "R5 R7 word mode32");
  endtask

  task automatic test_dword();
    do_load(64'h8000_0000_0000_0001, 2'd3, 1'b0, 1'b0, 64'h8000_0000_0000_0001, "R6 dword mode32");
    do_load(64'hFEDC_BA98_7654_3210, 2'd3, 1'b1, 1'b1, 64'hFEDC_BA98_7654_3210, "R6 dword mode64");
  endtask

  task automatic test_shift64();
    do_shift(64'h8000_0000_0000_0000, 6'd4,  1'b1, 1'b1, 64'hF800_0000_0000_0000, "R8 arith 4");
    do_shift(64'h8000_0000_0000_0000, 6'd4,  1'b0, 1'b1, 64'h0800_0000_0000_0000, "R8 logical 4");
    do_shift(64'h8000_0000_0000_0000, 6'd63, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, "R8 arith 63");
    do_shift(64'h8000_0000_0000_0000, 6'd63, 1'b0, 1'b1, 64'h0000_0000_0000_0001, "R8 logical 63");
    do_shift(64'h0000_0001_0000_0000, 6'd32, 1'b1, 1'b1, 64'h0000_0000_0000_0001, "R8 amount bit5 used");
  endtask

  task automatic test_shift32();
    do_shift(64'h0000_0000_8000_0000, 6'd4,  1'b1, 1'b0, 64'hFFFF_FFFF_F800_0000, "R9 R10 arith 4");
    do_shift(64'h1234_5678_8000_0000, 6'd36, 1'b1, 1'b0, 64'hFFFF_FFFF_F800_0000, "R9 amt bit5 and upper ignored");
    do_shift(64'hFFFF_FFFF_8000_0000, 6'd4,  1'b0, 1'b0, 64'h0000_0000_0800_0000, "R9 logical 4");
    do_shift(64'hFFFF_FFFF_8000_0000, 6'd0,  1'b0, 1'b0, 64'h0000_0000_8000_0000, "R10 logical zero-extend");
    do_shift(64'h0000_0000_8000_0000, 6'd0,  1'b1, 1'b0, 64'hFFFF_FFFF_8000_0000, "R10 arith sign-extend");
    do_shift(64'hFFFF_FFFF_4000_0000, 6'd31, 1'b1, 1'b0, 64'h0000_0000_0000_0000, "R10 arith positive");
  endtask

  task automatic test_hold();
    do_load(64'h0000_0000_0000_00A5, 2'd3, 1'b0, 1'b1, 64'h0000_0000_0000_00A5, "R6 before idle");
    ld_data = 64'hFFFF_FFFF_FFFF_FFFF; op_shift = 1'b0; ld_size = 2'd3;
    @(negedge clk);
    check("R2 idle valid", {63'd0, res_valid}, 64'd0);
    check("R11 hold", res_data, 64'h0000_0000_0000_00A5);
    @(negedge clk);
    check("R11 hold second", res_data, 64'h0000_0000_0000_00A5);
  endtask

  initial begin
    test_reset();
    test_byte_half();
    test_word();
    test_dword();
    test_shift64();
    test_shift32();
    test_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule